// File: doc/BRIEF.md
# Acquired-Line Transfer Register

This block sits between a data-line acquisition front end and a host read port. While a broadcast data line is being received, the front end presents one byte per cycle, tagged with its position in the line and with a flag that marks a biphase decoding fault. Selected positions are collected in a shadow buffer. When the end-of-line strobe arrives, the buffered window is copied into a 16-byte transfer register in one cycle. The copy happens only if the line was fault-free and the host is not reading at that moment.

A mode input picks which byte positions are kept. Line mode keeps one contiguous run of positions in arrival order. The two header modes each keep two 8-byte runs and place the later run first. The host raises an access signal and then pulls bytes one at a time. It learns of fresh data from an active-low flag that drops on every completed transfer and rises again when the next access begins.

Top module: `line_xfer_reg`

## Requirements
- R1: After synchronous reset, `avail_n` is 1 and every transfer register byte reads 0xFF.
- R2: With `mode_sel` 0 (line mode, and also the unused code 3), transfer slot k holds the byte at position LINE_BASE+k (default LINE_BASE = 0) for k = 0..15. All other positions are ignored.
- R3: With `mode_sel` 1 (header mode A), slots 0..7 hold positions 38..45 and slots 8..15 hold positions 30..37.
- R4: With `mode_sel` 2 (header mode B), slots 0..7 hold positions 22..29 and slots 8..15 hold positions 14..21.
- R5: A line in which any byte carried `acq_err` = 1 is discarded. The transfer register keeps its previous content and `avail_n` does not fall.
- R6: The transfer register changes only on an end-of-line strobe. Bytes received mid-line are not visible to the host until that line ends.
- R7: A line that ends while `host_active` is 1 is dropped, not queued. The next clean line that ends after the access is stored normally.
- R8: `avail_n` falls in the clock edge that stores a line. It rises in the first edge at which `host_active` is seen high after being low.
- R9: The read pointer is 0 at the start of every access and advances by one on each `host_rd` cycle. Reads beyond slot 15 return 0xFF.
- R10: Slots whose positions did not arrive during the stored line read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | 0 line, 1 header A, 2 header B, 3 as line |
| acq_valid | input | 1 | A byte is presented this cycle |
| acq_index | input | 6 | Position of the byte in the line |
| acq_byte | input | 8 | Byte value |
| acq_err | input | 1 | Biphase fault on this byte |
| acq_eol | input | 1 | End-of-line strobe |
| host_active | input | 1 | Host read access in progress |
| host_rd | input | 1 | Advance read pointer after this cycle |
| rd_data | output | 8 | Byte at the read pointer |
| avail_n | output | 1 | Active-low fresh-data flag |

## Verification
A wrong slot mapping shows up as misplaced bytes on the first read access after the line ends, so every mode is read back in full. If the fault flag does not stick, or the access inhibit leaks, the transfer register content changes and `avail_n` drops in the edge after the strobe. The bench samples `avail_n` one cycle after each strobe and re-reads the register. A pointer that fails to restart shows up on the very first byte of the next access.

// File: rtl/lxr_pkg.sv
// Package: shared mode encoding for the acquired-line transfer register.
// Assumes: the mode input is two bits wide; code 3 is decoded as line mode.
package lxr_pkg;

    typedef enum logic [1:0] {
        MODE_LINE  = 2'd0,
        MODE_HDR_A = 2'd1,
        MODE_HDR_B = 2'd2,
        MODE_SPARE = 2'd3
    } lxr_mode_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lxr_slot_map.sv
// Module: lxr_slot_map
// Maps an incoming byte position to a transfer-register slot for the current mode.
// Assumes: the two header windows of a mode do not overlap; NBYTES is even.
module lxr_slot_map
    import lxr_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int NBYTES    = 16,
    parameter int LINE_BASE = 0,
    parameter int A_FIRST   = 38,
    parameter int A_SECOND  = 30,
    parameter int B_FIRST   = 22,
    parameter int B_SECOND  = 14,
    localparam int SLOT_W   = $clog2(NBYTES),
    localparam int HALF     = NBYTES / 2
) (
    input  lxr_mode_e          mode,
    input  logic [IDX_W-1:0]   idx,
    output logic               keep,
    output logic [SLOT_W-1:0]  slot
);

    function automatic logic in_win(input int pos, input int base, input int len);
        return (pos >= base) && (pos < base + len);
    endfunction

    int pos;
    assign pos = int'(idx);

    // Decode keep flag and slot number from the position and mode.
    always_comb begin
        keep = 1'b0;
        slot = '0;
        case (mode)
            MODE_HDR_A: begin
                if (in_win(pos, A_FIRST, HALF)) begin
                    keep = 1'b1;
                    slot = SLOT_W'(pos - A_FIRST);
                end else if (in_win(pos, A_SECOND, HALF)) begin
                    keep = 1'b1;
                    slot = SLOT_W'(HALF + pos - A_SECOND);
                end
            end
            MODE_HDR_B: begin
                if (in_win(pos, B_FIRST, HALF)) begin
                    keep = 1'b1;
                    slot = SLOT_W'(pos - B_FIRST);
                end else if (in_win(pos, B_SECOND, HALF)) begin
                    keep = 1'b1;
                    slot = SLOT_W'(HALF + pos - B_SECOND);
                end
            end
            default: begin
                if (in_win(pos, LINE_BASE, NBYTES)) begin
                    keep = 1'b1;
                    slot = SLOT_W'(pos - LINE_BASE);
                end
            end
        endcase
    end

    // R3/R4: a header-mode keep must map into its own window half.
    always_comb begin
        if (keep && (mode == MODE_HDR_A) && in_win(pos, A_FIRST, HALF))
            a_r3_first_half: assert (int'(slot) < HALF);
        if (keep && (mode == MODE_HDR_B) && in_win(pos, B_SECOND, HALF))
            a_r4_second_half: assert (int'(slot) >= HALF);
    end

endmodule

// File: rtl/lxr_capture.sv
// Module: lxr_capture
// Collects kept bytes of the current line into a shadow buffer and tracks faults.
// Decides at the end-of-line strobe whether the line may be committed.
// Assumes: at most one byte per cycle; a byte may coincide with the strobe.
module lxr_capture
    import lxr_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int NBYTES    = 16,
    parameter int LINE_BASE = 0,
    parameter int A_FIRST   = 38,
    parameter int A_SECOND  = 30,
    parameter int B_FIRST   = 22,
    parameter int B_SECOND  = 14,
    localparam int SLOT_W   = $clog2(NBYTES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  lxr_mode_e                        mode,
    input  logic                             acq_valid,
    input  logic [IDX_W-1:0]                 acq_index,
    input  logic [BYTE_W-1:0]                acq_byte,
    input  logic                             acq_err,
    input  logic                             acq_eol,
    input  logic                             host_active,
    output logic                             commit,
    output logic [NBYTES-1:0][BYTE_W-1:0]    line_out
);

    logic                            keep;
    logic [SLOT_W-1:0]               slot;
    logic [NBYTES-1:0][BYTE_W-1:0]   shadow_q, shadow_d;
    logic                            line_bad_q, bad_now;

    lxr_slot_map #(
        .IDX_W(IDX_W), .NBYTES(NBYTES), .LINE_BASE(LINE_BASE),
        .A_FIRST(A_FIRST), .A_SECOND(A_SECOND),
        .B_FIRST(B_FIRST), .B_SECOND(B_SECOND)
    ) u_map (
        .mode (mode),
        .idx  (acq_index),
        .keep (keep),
        .slot (slot)
    );

    // Merge this cycle's byte into the shadow view.
    always_comb begin
        shadow_d = shadow_q;
        if (acq_valid && keep)
            shadow_d[slot] = acq_byte;
    end

    // Line is bad if any earlier byte or this byte carried a fault.
    assign bad_now  = line_bad_q | (acq_valid & acq_err);
    assign commit   = acq_eol & ~bad_now & ~host_active;
    assign line_out = shadow_d;

    // Shadow buffer and fault flag; both restart at every line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q   <= '1;
            line_bad_q <= 1'b0;
        end else if (acq_eol) begin
            shadow_q   <= '1;
            line_bad_q <= 1'b0;
        end else begin
            shadow_q   <= shadow_d;
            line_bad_q <= bad_now;
        end
    end

    a_r5_fault_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_valid && acq_err && !acq_eol) |=> line_bad_q);

    a_r5_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        line_bad_q |-> !commit);

    a_r10_fresh_line: assert property (@(posedge clk) disable iff (!rst_n)
        acq_eol |=> (!line_bad_q && (shadow_q == '1)));

endmodule

// File: rtl/lxr_xfer_port.sv
// Module: lxr_xfer_port
// Holds the transfer register and serves host reads.
// Drives the active-low fresh-data flag.
// Assumes: commit is never raised while host_active is high.
module lxr_xfer_port
    import lxr_pkg::*;
#(
    parameter int NBYTES  = 16,
    localparam int SLOT_W = $clog2(NBYTES),
    localparam int PTR_W  = $clog2(NBYTES + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit,
    input  logic [NBYTES-1:0][BYTE_W-1:0]  line_in,
    input  logic                           host_active,
    input  logic                           host_rd,
    output logic [BYTE_W-1:0]              rd_data,
    output logic                           avail_n
);

    logic [NBYTES-1:0][BYTE_W-1:0] xreg_q;
    logic                          active_q;
    logic [PTR_W-1:0]              ptr_q;

    // Transfer register: loaded whole on commit only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            xreg_q <= '1;
        else if (commit)
            xreg_q <= line_in;
    end

    // Delayed access signal for start-of-access detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else
            active_q <= host_active;
    end

    // Fresh-data flag: low after a transfer, high once an access starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            avail_n <= 1'b1;
        else if (commit)
            avail_n <= 1'b0;
        else if (host_active && !active_q)
            avail_n <= 1'b1;
    end

    // Read pointer: held at zero between accesses, saturates past the end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (!host_active)
            ptr_q <= '0;
        else if (host_rd && (ptr_q < PTR_W'(NBYTES)))
            ptr_q <= ptr_q + 1'b1;
    end

    // Byte at the pointer, or the filler value past the end.
    assign rd_data = (ptr_q < PTR_W'(NBYTES)) ? xreg_q[ptr_q[SLOT_W-1:0]] : 8'hFF;

    a_r8_fall_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(avail_n) |-> $past(commit));

    a_r8_rise_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_active) |=> avail_n);

    a_r7_hold_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        host_active |=> $stable(xreg_q));

    a_r9_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_active) |-> (ptr_q == '0));

    a_r9_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == PTR_W'(NBYTES)) |-> (rd_data == 8'hFF));

endmodule

// File: rtl/line_xfer_reg.sv
// Module: line_xfer_reg (top)
// Captures selected bytes of a received data line into a host-readable register.
// Assumes: the host holds host_active for the whole read and drops it between reads.
module line_xfer_reg
    import lxr_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int NBYTES    = 16,
    parameter int LINE_BASE = 0,
    parameter int A_FIRST   = 38,
    parameter int A_SECOND  = 30,
    parameter int B_FIRST   = 22,
    parameter int B_SECOND  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              acq_valid,
    input  logic [IDX_W-1:0]  acq_index,
    input  logic [7:0]        acq_byte,
    input  logic              acq_err,
    input  logic              acq_eol,
    input  logic              host_active,
    input  logic              host_rd,
    output logic [7:0]        rd_data,
    output logic              avail_n
);

    logic                          commit;
    logic [NBYTES-1:0][BYTE_W-1:0] line_bus;
    lxr_mode_e                     mode;

    assign mode = lxr_mode_e'(mode_sel);

    lxr_capture #(
        .IDX_W(IDX_W), .NBYTES(NBYTES), .LINE_BASE(LINE_BASE),
        .A_FIRST(A_FIRST), .A_SECOND(A_SECOND),
        .B_FIRST(B_FIRST), .B_SECOND(B_SECOND)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .acq_valid   (acq_valid),
        .acq_index   (acq_index),
        .acq_byte    (acq_byte),
        .acq_err     (acq_err),
        .acq_eol     (acq_eol),
        .host_active (host_active),
        .commit      (commit),
        .line_out    (line_bus)
    );

    lxr_xfer_port #(
        .NBYTES(NBYTES)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .line_in     (line_bus),
        .host_active (host_active),
        .host_rd     (host_rd),
        .rd_data     (rd_data),
        .avail_n     (avail_n)
    );

    a_r7_no_store_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        host_active |=> !$fell(avail_n));

endmodule

// File: tb/line_xfer_reg_test.sv
module line_xfer_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       acq_valid = 1'b0;
    logic [5:0] acq_index = '0;
    logic [7:0] acq_byte = '0;
    logic       acq_err = 1'b0;
    logic       acq_eol = 1'b0;
    logic       host_active = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] rd_data;
    logic       avail_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] exp_reg [16];
    logic [7:0] sh      [16];
    bit         sh_bad;
    logic       exp_avail;

    always #4 clk = ~clk;

    line_xfer_reg uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .acq_valid(acq_valid), .acq_index(acq_index), .acq_byte(acq_byte),
        .acq_err(acq_err), .acq_eol(acq_eol),
        .host_active(host_active), .host_rd(host_rd),
        .rd_data(rd_data), .avail_n(avail_n)
    );

    function automatic logic [7:0] bval(input logic [7:0] seed, input int idx);
        return seed ^ 8'(idx * 13);
    endfunction

    // Expected slot per requirement R2/R3/R4; -1 when the position is dropped.
    function automatic int exp_slot(input int mode, input int idx);
        if (mode == 1) begin
            if (idx >= 38 && idx <= 45) return idx - 38;
            if (idx >= 30 && idx <= 37) return idx - 30 + 8;
            return -1;
        end
        if (mode == 2) begin
            if (idx >= 22 && idx <= 29) return idx - 22;
            if (idx >= 14 && idx <= 21) return idx - 14 + 8;
            return -1;
        end
        if (idx >= 0 && idx <= 15) return idx;
        return -1;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic drive_bytes(input int mode, input logic [7:0] seed,
                               input int first, input int last, input int err_idx);
        mode_sel = 2'(mode);
        for (int i = first; i <= last; i++) begin
            acq_valid = 1'b1;
            acq_index = 6'(i);
            acq_byte  = bval(seed, i);
            acq_err   = (i == err_idx);
            if (i == err_idx) sh_bad = 1'b1;
            if (exp_slot(mode, i) >= 0) sh[exp_slot(mode, i)] = bval(seed, i);
            @(negedge clk);
        end
        acq_valid = 1'b0;
        acq_err   = 1'b0;
    endtask

    task automatic end_line(input string req);
        bit stored;
        stored  = !sh_bad && !host_active;
        acq_eol = 1'b1;
        @(negedge clk);
        acq_eol = 1'b0;
        if (stored) begin
            for (int k = 0; k < 16; k++) exp_reg[k] = sh[k];
            exp_avail = 1'b0;
        end
        for (int k = 0; k < 16; k++) sh[k] = 8'hFF;
        sh_bad = 1'b0;
        check8(req, {7'd0, avail_n}, {7'd0, exp_avail});
    endtask

    task automatic read_check(input string req, input int nreads);
        host_active = 1'b1;
        host_rd     = 1'b0;
        @(negedge clk);
        exp_avail = 1'b1;
        check8("R8 avail rises on access", {7'd0, avail_n}, 8'd1);
        for (int k = 0; k < nreads; k++) begin
            check8(req, rd_data, (k < 16) ? exp_reg[k] : 8'hFF);
            host_rd = 1'b1;
            @(negedge clk);
        end
        host_rd     = 1'b0;
        host_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check8("R1 avail after reset", {7'd0, avail_n}, 8'd1);
        read_check("R1 reset content / R9 past end", 18);
    endtask

    task automatic t_line_mode();
        drive_bytes(0, 8'h11, 0, 47, -1);
        end_line("R8 avail falls on store");
        read_check("R2 line mode", 18);
    endtask

    task automatic t_hdr_a();
        drive_bytes(1, 8'h5A, 0, 47, -1);
        end_line("R8 avail falls on store");
        read_check("R3 header A order", 16);
    endtask

    task automatic t_hdr_b();
        drive_bytes(2, 8'hC3, 0, 47, -1);
        end_line("R8 avail falls on store");
        read_check("R4 header B order", 16);
    endtask

    task automatic t_spare_mode();
        drive_bytes(3, 8'h27, 0, 47, -1);
        end_line("R2 code 3 stored");
        read_check("R2 code 3 as line mode", 16);
    endtask

    task automatic t_error_line();
        drive_bytes(1, 8'h99, 0, 47, 40);
        end_line("R5 avail stays high on bad line");
        read_check("R5 bad line discarded", 16);
        drive_bytes(0, 8'h3C, 0, 15, 0);
        end_line("R5 fault on first byte");
        read_check("R5 first-byte fault discarded", 16);
    endtask

    task automatic t_midline();
        drive_bytes(0, 8'h44, 0, 20, -1);
        read_check("R6 mid-line content unchanged", 16);
        drive_bytes(0, 8'h44, 21, 47, -1);
        end_line("R6 store at line end");
        read_check("R6 line stored at end", 16);
    endtask

    task automatic t_inhibit();
        host_active = 1'b1;
        @(negedge clk);
        exp_avail = 1'b1;
        drive_bytes(2, 8'hE1, 0, 47, -1);
        end_line("R7 no store in access");
        host_active = 1'b0;
        @(negedge clk);
        read_check("R7 dropped line", 16);
        drive_bytes(2, 8'h0F, 0, 47, -1);
        end_line("R7 next line stored");
        read_check("R7 next clean line", 16);
    endtask

    task automatic t_short_line();
        drive_bytes(0, 8'h70, 2, 6, -1);
        end_line("R10 short line stored");
        read_check("R10 missing slots read FF", 16);
    endtask

    task automatic t_ptr_restart();
        read_check("R9 partial access", 3);
        read_check("R9 pointer restarts", 18);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            exp_reg[k] = 8'hFF;
            sh[k]      = 8'hFF;
        end
        sh_bad    = 1'b0;
        exp_avail = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_line_mode();
        t_hdr_a();
        t_hdr_b();
        t_spare_mode();
        t_error_line();
        t_midline();
        t_inhibit();
        t_short_line();
        t_ptr_restart();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule